// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two unsigned base-3 numbers and an incoming carry digit. Every ternary digit travels on two binary wires: 00 stands for 0, 01 for 1 and 10 for 2. The operands are packed little-endian, with digit 0 in the two least significant bits. The result is a sum vector of the same width and one carry-out digit. The block has no clock and no state. Its outputs follow its inputs through a chain of combinational full-adder cells.

Each cell adds two operand digits and a carry digit, so its total lies between 0 and 6. The cell returns the total modulo 3 as its sum digit and the total divided by 3 as its outgoing carry. That carry may therefore be 2, and it enters the cell one place more significant. Any digit carrying the unused code 11 raises an error output. While the error output is high, the sum and carry-out outputs are held at zero.

Top module: `tern_ripple_adder`

## Requirements
- R1: Digit codes are 2'b00 = 0, 2'b01 = 1, 2'b10 = 2, and digit i of a vector occupies bits [2i+1:2i], with digit 0 least significant.
- R2: With all inputs legal, each sum digit equals (a + b + carry into that digit) mod 3.
- R3: The carry out of each digit equals floor((a + b + carry into that digit) / 3), and the final carry-out may be 0, 1 or 2.
- R4: A digit with a = 2, b = 2 and incoming carry 2 gives sum 0 and carry 2. The pair 1 + 2 gives sum 0 and carry 1, and 2 + 2 gives sum 1 and carry 1.
- R5: The carry of digit i feeds digit i+1, so that value(sum) + 3^N * cout = value(opa) + value(opb) + cin.
- R6: The carry-in input accepts the values 0, 1 and 2, and each one is added at digit 0.
- R7: The error flag is 1 exactly when some digit of opa, some digit of opb, or cin carries the code 2'b11.
- R8: While the error flag is 1, every sum digit and the carry-out are 2'b00.
- R9: No sum digit and no carry-out ever carries the code 2'b11.
- R10: The block is purely combinational, so a change at the inputs reaches the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 2*N_TRITS | First operand, one 2-bit code per ternary digit |
| opb | input | 2*N_TRITS | Second operand, same packing |
| cin | input | 2 | Carry digit added at digit 0 |
| sum | output | 2*N_TRITS | Sum digits, same packing |
| cout | output | 2 | Carry out of the most significant digit |
| err | output | 1 | High when any input digit uses the illegal code |

## Verification
The bench builds three copies of the block. The first has N_TRITS = 1 and exercises all 27 cell input combinations, including the 2+2+2 corner. The second has N_TRITS = 3 and is driven with every pair of operands and every carry-in, 2187 cases in total. This covers every ripple path, including a carry of 2 entering and leaving each position, and it is also used to inject the illegal code into each digit position and into the carry-in. The third has the default width of six digits. It receives random operand pairs together with the all-2 extremes, which test the longest carry propagation.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_0   = 2'b00;
    localparam trit_t TRIT_1   = 2'b01;
    localparam trit_t TRIT_2   = 2'b10;
    localparam trit_t TRIT_BAD = 2'b11;

    localparam int TRIT_W = 2;

endpackage

// File: rtl/tern_legal_scan.sv
module tern_legal_scan
    import tern_pkg::*;
#(
    parameter int N_TRITS = 6,
    localparam int VEC_W = N_TRITS * TRIT_W
) (
    input  logic [VEC_W-1:0] vec,
    output logic             any_bad
);

    logic [N_TRITS-1:0] bad;

    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_scan
        assign bad[gi] = (vec[gi*TRIT_W +: TRIT_W] == TRIT_BAD);
    end

    assign any_bad = |bad;

endmodule

// File: rtl/tern_full_add.sv
module tern_full_add
    import tern_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    input  trit_t ci,
    output trit_t s,
    output trit_t co
);

    logic [3:0] total;

    assign total = {2'b00, a} + {2'b00, b} + {2'b00, ci};

    always_comb begin
        unique case (total)
            4'd0:    begin s = TRIT_0; co = TRIT_0; end
            4'd1:    begin s = TRIT_1; co = TRIT_0; end
            4'd2:    begin s = TRIT_2; co = TRIT_0; end
            4'd3:    begin s = TRIT_0; co = TRIT_1; end
            4'd4:    begin s = TRIT_1; co = TRIT_1; end
            4'd5:    begin s = TRIT_2; co = TRIT_1; end
            4'd6:    begin s = TRIT_0; co = TRIT_2; end
            default: begin s = TRIT_0; co = TRIT_0; end
        endcase
    end

endmodule

// File: rtl/tern_carry_chain.sv
module tern_carry_chain
    import tern_pkg::*;
#(
    parameter int N_TRITS = 6,
    localparam int VEC_W = N_TRITS * TRIT_W
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  trit_t            ci,
    output logic [VEC_W-1:0] s,
    output trit_t            co
);

    trit_t carry [N_TRITS+1];

    assign carry[0] = ci;

    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_cell
        tern_full_add u_cell (
            .a  (a[gi*TRIT_W +: TRIT_W]),
            .b  (b[gi*TRIT_W +: TRIT_W]),
            .ci (carry[gi]),
            .s  (s[gi*TRIT_W +: TRIT_W]),
            .co (carry[gi+1])
        );
    end

    assign co = carry[N_TRITS];

endmodule

// File: rtl/tern_ripple_adder.sv
module tern_ripple_adder
    import tern_pkg::*;
#(
    parameter int N_TRITS = 6,
    localparam int VEC_W = N_TRITS * TRIT_W
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic [1:0]       cin,
    output logic [VEC_W-1:0] sum,
    output logic [1:0]       cout,
    output logic             err
);

    logic             bad_a;
    logic             bad_b;
    logic             bad_c;
    logic [VEC_W-1:0] raw_sum;
    trit_t            raw_co;

    tern_legal_scan #(.N_TRITS(N_TRITS)) u_scan_a (.vec(opa), .any_bad(bad_a));
    tern_legal_scan #(.N_TRITS(N_TRITS)) u_scan_b (.vec(opb), .any_bad(bad_b));
    tern_legal_scan #(.N_TRITS(1))       u_scan_c (.vec(cin), .any_bad(bad_c));

    tern_carry_chain #(.N_TRITS(N_TRITS)) u_chain (
        .a  (opa),
        .b  (opb),
        .ci (cin),
        .s  (raw_sum),
        .co (raw_co)
    );

    always_comb begin
        err  = bad_a | bad_b | bad_c;
        sum  = err ? '0 : raw_sum;
        cout = err ? TRIT_0 : raw_co;
    end

endmodule

// File: rtl/tern_ripple_adder_chk.sv
module tern_ripple_adder_chk #(
    parameter int N_TRITS = 6,
    localparam int VEC_W = N_TRITS * 2
) (
    input logic [VEC_W-1:0] opa,
    input logic [VEC_W-1:0] opb,
    input logic [1:0]       cin,
    input logic [VEC_W-1:0] sum,
    input logic [1:0]       cout,
    input logic             err
);

    logic   saw_bad;
    logic   out_bad;
    longint va, vb, vs, wt;

    always_comb begin
        saw_bad = (cin == 2'b11);
        out_bad = (cout == 2'b11);
        va = 0; vb = 0; vs = 0; wt = 1;
        for (int i = 0; i < N_TRITS; i++) begin
            saw_bad = saw_bad | (opa[2*i +: 2] == 2'b11) | (opb[2*i +: 2] == 2'b11);
            out_bad = out_bad | (sum[2*i +: 2] == 2'b11);
            va = va + wt * longint'(opa[2*i +: 2]);
            vb = vb + wt * longint'(opb[2*i +: 2]);
            vs = vs + wt * longint'(sum[2*i +: 2]);
            wt = wt * 3;
        end
    end

    always_comb begin
        a_r7_err_flag: assert (err == saw_bad);
        a_r8_err_zeroes: assert (!err || (sum == '0 && cout == 2'b00));
        a_r9_legal_outputs: assert (!out_bad);
        a_r5_value_holds: assert (err || (vs + wt * longint'(cout) == va + vb + longint'(cin)));
    end

endmodule

bind tern_ripple_adder tern_ripple_adder_chk #(.N_TRITS(N_TRITS)) u_chk (
    .opa  (opa),
    .opb  (opb),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .err  (err)
);

// File: tb/test_tern_ripple_adder.sv
module test_tern_ripple_adder;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0]  a1 = '0, b1 = '0, c1 = '0;
    logic [1:0]  s1, co1;
    logic        e1;
    logic [5:0]  a3 = '0, b3 = '0;
    logic [1:0]  c3 = '0;
    logic [5:0]  s3;
    logic [1:0]  co3;
    logic        e3;
    logic [11:0] a6 = '0, b6 = '0;
    logic [1:0]  c6 = '0;
    logic [11:0] s6;
    logic [1:0]  co6;
    logic        e6;

    tern_ripple_adder #(.N_TRITS(1)) i_tern_ripple_adder_n1 (
        .opa(a1), .opb(b1), .cin(c1), .sum(s1), .cout(co1), .err(e1));
    tern_ripple_adder #(.N_TRITS(3)) i_tern_ripple_adder (
        .opa(a3), .opb(b3), .cin(c3), .sum(s3), .cout(co3), .err(e3));
    tern_ripple_adder i_tern_ripple_adder_n6 (
        .opa(a6), .opb(b6), .cin(c6), .sum(s6), .cout(co6), .err(e6));

    // R1: digit i in bits [2i+1:2i], code = digit value
    function automatic logic [11:0] enc(input int v);
        logic [11:0] r = '0;
        int x = v;
        for (int i = 0; i < 6; i++) begin
            r[2*i +: 2] = 2'(x % 3);
            x = x / 3;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        int t;
        logic [11:0] e;
        // reset-like idle state: all zero inputs
        #5;
        check(s3 == 0 && co3 == 0 && !e3, "R5 idle zero", {s3, co3, e3}, 0);

        // R2 R3 R4 cell exhaustive through the single-digit copy
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++) begin
                    step();
                    a1 = 2'(a); b1 = 2'(b); c1 = 2'(c);
                    #5;
                    t = a + b + c;
                    check(s1 == 2'(t % 3), "R2 cell sum", s1, t % 3);
                    check(co1 == 2'(t / 3) && !e1, "R3 cell carry", co1, t / 3);
                end
        step(); a1 = 2'd2; b1 = 2'd2; c1 = 2'd2; #5;
        check(s1 == 2'd0 && co1 == 2'd2, "R4 2+2+2", {s1, co1}, 4'b0010);
        step(); a1 = 2'd1; b1 = 2'd2; c1 = 2'd0; #5;
        check(s1 == 2'd0 && co1 == 2'd1, "R4 1+2", {s1, co1}, 4'b0001);
        step(); a1 = 2'd2; b1 = 2'd2; c1 = 2'd0; #5;
        check(s1 == 2'd1 && co1 == 2'd1, "R4 2+2", {s1, co1}, 4'b0101);

        // R5 R6 exhaustive over three digits
        for (int a = 0; a < 27; a++)
            for (int b = 0; b < 27; b++)
                for (int c = 0; c < 3; c++) begin
                    step();
                    e = enc(a); a3 = e[5:0];
                    e = enc(b); b3 = e[5:0];
                    c3 = 2'(c);
                    #5;
                    t = a + b + c;
                    e = enc(t % 27);
                    check(s3 == e[5:0] && co3 == 2'(t / 27) && !e3,
                          c == 0 ? "R5 ripple" : "R6 carry-in", {s3, co3}, {e[5:0], 2'(t / 27)});
                end

        // R10: combinational response, no clock edge between change and sample
        @(posedge clk); #1;
        a3 = enc(26)[5:0]; b3 = enc(1)[5:0]; c3 = 2'd0;
        #1;
        check(s3 == 6'd0 && co3 == 2'd1, "R10 no clock", {s3, co3}, 1);

        // R7 R8 illegal code at each position
        for (int p = 0; p < 7; p++) begin
            step();
            a3 = enc(14)[5:0]; b3 = enc(25)[5:0]; c3 = 2'd2;
            if (p < 3) a3[2*p +: 2] = 2'b11;
            else if (p < 6) b3[2*(p-3) +: 2] = 2'b11;
            else c3 = 2'b11;
            #5;
            check(e3, "R7 illegal raises err", e3, 1);
            check(s3 == 0 && co3 == 0, "R8 outputs zeroed", {s3, co3}, 0);
        end
        step(); a3 = enc(14)[5:0]; b3 = enc(25)[5:0]; c3 = 2'd2; #5;
        check(!e3, "R7 legal clears err", e3, 0);

        // R9 + R5 at default width: extremes and random
        step(); a6 = enc(728); b6 = enc(728); c6 = 2'd2; #5;
        check(s6 == enc(1458 % 729) && co6 == 2'd2, "R9 all-2 extreme", {s6, co6}, {enc(0), 2'd2});
        for (int k = 0; k < 500; k++) begin
            int x, y, z;
            x = int'($urandom % 729); y = int'($urandom % 729); z = int'($urandom % 3);
            step();
            a6 = enc(x); b6 = enc(y); c6 = 2'(z);
            #5;
            t = x + y + z;
            check(s6 == enc(t % 729) && co6 == 2'(t / 729) && !e6, "R5 random width 6",
                  {s6, co6}, {enc(t % 729), 2'(t / 729)});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule